// File: doc/BRIEF.md
# PCI Window DMA Address Translator

This block turns addresses arriving from a PCI bus into system DMA addresses. Software programs a small set of address windows through a 64-bit register port. Each window has a base, a mask and a translated-base register. When a bus address falls inside an enabled window, the window either remaps it directly or looks it up through a scatter-gather page table in system memory. An address that falls inside no enabled window leaves the block unchanged.

Translation requests come in on a valid/ready port, and each request gets a single-cycle response pulse. A scatter-gather lookup issues one 64-bit read on a memory port. The translate port stays busy until that read returns, and the block then forms the final address. Register accesses answer one cycle after the request. An illegal access size or an unmapped offset gets an error response.

Top module: `pci_dma_xlate`

## Requirements
- R1: After reset every window base, mask and translated-base register reads 0, and the control register reads 0x0000_0021_0010_0000 (bits 20 and 32 set, value 2 in the field at bit 36).
- R2: A register access at address A selects offset (A - DEV_BASE) >> 6. The offsets are: window i base at i, window i mask at 4+i, window i translated base at 8+i, control at 12, error status at 13, error mask at 14, invalidate-all at 15. Only 8-byte accesses are legal. reg_rsp_valid pulses in the cycle after reg_req, and a legal write is visible to a read that follows it.
- R3: An access with a size other than 8, an address below DEV_BASE, or an offset above 15 returns reg_err=1 with reg_rdata=0 and changes no register.
- R4: The error status, error mask and invalidate-all registers read 0. Writes to error status and to invalidate-all are accepted without error and have no effect. A write to the error mask returns an error.
- R5: Window i hits when the bus address and the window base agree on every bit in 31:20 where the mask register holds 0. All other bits are ignored in the comparison.
- R6: Base bit 0 enables a window. A window that hits but is disabled is skipped.
- R7: When several enabled windows hit, the lowest-numbered one is used.
- R8: Base bit 1 clear selects direct mode. Let P be (mask & 0xFFF00000) | 0xFFFFF. The result is (translated base & ~P) | (bus address & P).
- R9: Base bit 1 set selects scatter-gather mode. The block issues exactly one single-cycle mem_req_valid at address (tbase & ~(((mask & 0xFFF00000) >> 10) | 0x3FF)) | ((addr & ((mask & 0xFFF00000) | (0x7F << 13))) >> 10). xl_ready stays low until mem_rsp_valid.
- R10: A scatter-gather result is ((entry & ~1) << 12) | bus address bits 12:0.
- R11: Every translated result is truncated to its low 34 bits. An address that hits no enabled window is returned unchanged in all 64 bits.
- R12: xl_ready is high whenever no fetch is outstanding. A request is taken when xl_valid and xl_ready are both high. xl_rsp_valid pulses in the cycle after acceptance for direct and pass-through requests, and in the cycle after mem_rsp_valid for scatter-gather requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 64 | Register access byte address |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data |
| reg_rsp_valid | output | 1 | Register response pulse |
| reg_rdata | output | 64 | Read data (0 on writes and errors) |
| reg_err | output | 1 | Access error flag |
| xl_valid | input | 1 | Translate request valid |
| xl_ready | output | 1 | Translate port can accept |
| xl_addr | input | 64 | Bus address to translate |
| xl_rsp_valid | output | 1 | Translation result pulse |
| xl_rsp_addr | output | 64 | Translated or passed-through address |
| mem_req_valid | output | 1 | Page-table entry read request |
| mem_req_addr | output | 64 | Page-table entry address |
| mem_rsp_valid | input | 1 | Page-table entry data valid |
| mem_rsp_data | input | 64 | Page-table entry |

## Verification
The assertions assume the memory side answers each read with exactly one mem_rsp_valid pulse. That pulse comes no earlier than the cycle after mem_req_valid and never while no fetch is outstanding. They also assume xl_valid only carries a new request while xl_ready is high. The stimulus follows these rules. It drives a request only in an idle cycle. It raises mem_rsp_valid for one cycle after a random gap that begins once the read request has been seen. It never raises mem_rsp_valid outside a scatter-gather lookup. Random window settings mix enabled, disabled, direct and scatter-gather windows. Most addresses are forced to hit a chosen window's compare bits, so the priority and skip rules are exercised often.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  localparam int unsigned DW = 64;

  // Window field of the address compared against the base register
  localparam logic [DW-1:0] WIN_FIELD = 64'h0000_0000_FFF0_0000;

  // Control register value after reset
  localparam logic [DW-1:0] CTRL_RST = (64'd1 << 20) | (64'd1 << 32) | (64'd2 << 36);

  localparam int unsigned EN_BIT = 0;
  localparam int unsigned SG_BIT = 1;

  typedef struct packed {
    logic [DW-1:0] base;
    logic [DW-1:0] mask;
    logic [DW-1:0] tbase;
  } xlt_win_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } xlt_state_e;

endpackage

// File: rtl/xlt_regfile.sv
module xlt_regfile
  import xlt_pkg::*;
#(
  parameter int unsigned     NUM_WIN   = 4,
  parameter logic [DW-1:0]   DEV_BASE  = 64'h0000_0000_1000_0000,
  parameter int unsigned     OFF_SHIFT = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_req,
  input  logic                         reg_we,
  input  logic [DW-1:0]                reg_addr,
  input  logic [3:0]                   reg_size,
  input  logic [DW-1:0]                reg_wdata,
  output logic                         reg_rsp_valid,
  output logic [DW-1:0]                reg_rdata,
  output logic                         reg_err,
  output xlt_win_t [NUM_WIN-1:0]       win_o
);

  localparam int unsigned OFF_MASK = NUM_WIN;
  localparam int unsigned OFF_TB   = 2 * NUM_WIN;
  localparam int unsigned OFF_CTRL = 3 * NUM_WIN;
  localparam int unsigned OFF_ERR  = OFF_CTRL + 1;
  localparam int unsigned OFF_EMSK = OFF_CTRL + 2;
  localparam int unsigned OFF_INV  = OFF_CTRL + 3;

  logic [DW-1:0]      rel_addr;
  logic [DW-1:0]      off;
  logic               in_range;
  logic               size_ok;
  logic               legal;
  logic               acc_ok;
  logic               do_wr;
  logic [DW-1:0]      rd_val;
  logic [NUM_WIN-1:0] sel_base, sel_mask, sel_tb;
  logic               sel_ctrl;
  logic [NUM_WIN-1:0] wr_base, wr_mask, wr_tb;
  logic               wr_ctrl;
  logic [DW-1:0]      ctrl_q, ctrl_d;

  logic               rsp_valid_q, rsp_valid_d;
  logic [DW-1:0]      rdata_q, rdata_d;
  logic               err_q, err_d;

  assign rel_addr = reg_addr - DEV_BASE;
  assign off      = rel_addr >> OFF_SHIFT;
  assign in_range = (reg_addr >= DEV_BASE);
  assign size_ok  = (reg_size == 4'd8);

  // Offset decode
  always_comb begin
    legal    = 1'b0;
    rd_val   = '0;
    sel_base = '0;
    sel_mask = '0;
    sel_tb   = '0;
    sel_ctrl = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (off == 64'(i)) begin
        legal       = 1'b1;
        rd_val      = win_o[i].base;
        sel_base[i] = 1'b1;
      end
      if (off == 64'(OFF_MASK + i)) begin
        legal       = 1'b1;
        rd_val      = win_o[i].mask;
        sel_mask[i] = 1'b1;
      end
      if (off == 64'(OFF_TB + i)) begin
        legal       = 1'b1;
        rd_val      = win_o[i].tbase;
        sel_tb[i]   = 1'b1;
      end
    end
    if (off == 64'(OFF_CTRL)) begin
      legal    = 1'b1;
      rd_val   = ctrl_q;
      sel_ctrl = 1'b1;
    end
    if (off == 64'(OFF_ERR) || off == 64'(OFF_INV)) begin
      legal  = 1'b1;
      rd_val = '0;
    end
    if (off == 64'(OFF_EMSK)) begin
      legal  = !reg_we;
      rd_val = '0;
    end
  end

  assign acc_ok  = in_range && size_ok && legal;
  assign do_wr   = reg_req && reg_we && acc_ok;
  assign wr_base = sel_base & {NUM_WIN{do_wr}};
  assign wr_mask = sel_mask & {NUM_WIN{do_wr}};
  assign wr_tb   = sel_tb   & {NUM_WIN{do_wr}};
  assign wr_ctrl = sel_ctrl && do_wr;

  // Window storage
  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic [DW-1:0] base_q, mask_q, tb_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        mask_q <= '0;
        tb_q   <= '0;
      end else begin
        if (wr_base[gi]) base_q <= reg_wdata;
        if (wr_mask[gi]) mask_q <= reg_wdata;
        if (wr_tb[gi])   tb_q   <= reg_wdata;
      end
    end

    assign win_o[gi].base  = base_q;
    assign win_o[gi].mask  = mask_q;
    assign win_o[gi].tbase = tb_q;
  end

  assign ctrl_d = reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

  // Response path
  always_comb begin
    rsp_valid_d = reg_req;
    rdata_d     = (reg_req && !reg_we && acc_ok) ? rd_val : '0;
    err_d       = reg_req && !acc_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
      err_q       <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (reg_req) begin
        rdata_q <= rdata_d;
        err_q   <= err_d;
      end
    end
  end

  assign reg_rsp_valid = rsp_valid_q;
  assign reg_rdata     = rdata_q;
  assign reg_err       = err_q;

endmodule

// File: rtl/xlt_match.sv
module xlt_match
  import xlt_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4
) (
  input  logic [DW-1:0]          addr,
  input  xlt_win_t [NUM_WIN-1:0] win_i,
  output logic                   hit,
  output logic                   sel_sg,
  output logic [DW-1:0]          sel_mask,
  output logic [DW-1:0]          sel_tbase
);

  logic [NUM_WIN-1:0] use_hit;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_cmp
    logic [DW-1:0] cmp_mask;
    logic          raw_hit;
    assign cmp_mask    = ~win_i[gi].mask & WIN_FIELD;
    assign raw_hit     = (((addr ^ win_i[gi].base) & cmp_mask) == '0);
    assign use_hit[gi] = raw_hit && win_i[gi].base[EN_BIT];
  end

  // Lowest index wins: scan from the top so the lowest assignment stands
  always_comb begin
    sel_sg    = 1'b0;
    sel_mask  = '0;
    sel_tbase = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (use_hit[i]) begin
        sel_sg    = win_i[i].base[SG_BIT];
        sel_mask  = win_i[i].mask;
        sel_tbase = win_i[i].tbase;
      end
    end
  end

  assign hit = |use_hit;

endmodule

// File: rtl/xlt_engine.sv
module xlt_engine
  import xlt_pkg::*;
#(
  parameter int unsigned OUT_BITS = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xl_valid,
  input  logic [DW-1:0] xl_addr,
  output logic          xl_ready,
  output logic          xl_rsp_valid,
  output logic [DW-1:0] xl_rsp_addr,
  output logic          rsp_xlated,
  input  logic          hit,
  input  logic          sel_sg,
  input  logic [DW-1:0] sel_mask,
  input  logic [DW-1:0] sel_tbase,
  output logic          mem_req_valid,
  output logic [DW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);

  localparam logic [DW-1:0] OUT_MASK  = (64'd1 << OUT_BITS) - 64'd1;
  localparam int unsigned   PG_SHIFT  = 12;
  localparam int unsigned   LOW_BITS  = 13;
  localparam logic [DW-1:0] LOW_MASK  = (64'd1 << LOW_BITS) - 64'd1;
  localparam logic [DW-1:0] DIR_LOW   = 64'h0000_0000_000F_FFFF;
  localparam logic [DW-1:0] SG_IDX    = 64'h7F << 13;
  localparam logic [DW-1:0] SG_ALIGN  = 64'h3FF;

  xlt_state_e    state_q, state_d;
  logic [DW-1:0] pte_addr_q, pte_addr_d;
  logic [DW-1:0] low_q, low_d;
  logic          rvalid_q, rvalid_d;
  logic [DW-1:0] raddr_q, raddr_d;
  logic          xlated_q, xlated_d;

  logic          accept;
  logic          go_sg;
  logic [DW-1:0] field;
  logic [DW-1:0] pass_mask;
  logic [DW-1:0] dir_res;
  logic [DW-1:0] pte_calc;
  logic [DW-1:0] sg_res;

  assign accept    = xl_valid && (state_q == ST_IDLE);
  assign go_sg     = accept && hit && sel_sg;
  assign field     = sel_mask & WIN_FIELD;
  assign pass_mask = field | DIR_LOW;
  assign dir_res   = ((sel_tbase & ~pass_mask) | (xl_addr & pass_mask)) & OUT_MASK;
  assign pte_calc  = (sel_tbase & ~((field >> 10) | SG_ALIGN))
                   | ((xl_addr & (field | SG_IDX)) >> 10);
  assign sg_res    = (((mem_rsp_data & ~64'd1) << PG_SHIFT) | low_q) & OUT_MASK;

  always_comb begin
    state_d    = state_q;
    pte_addr_d = pte_addr_q;
    low_d      = low_q;
    rvalid_d   = 1'b0;
    raddr_d    = raddr_q;
    xlated_d   = xlated_q;
    unique case (state_q)
      ST_IDLE: begin
        if (go_sg) begin
          state_d    = ST_REQ;
          pte_addr_d = pte_calc;
          low_d      = xl_addr & LOW_MASK;
        end else if (accept) begin
          rvalid_d = 1'b1;
          raddr_d  = hit ? dir_res : xl_addr;
          xlated_d = hit;
        end
      end
      ST_REQ: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          state_d  = ST_IDLE;
          rvalid_d = 1'b1;
          raddr_d  = sg_res;
          xlated_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pte_addr_q <= '0;
      low_q      <= '0;
      rvalid_q   <= 1'b0;
      raddr_q    <= '0;
      xlated_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= rvalid_d;
      if (go_sg) begin
        pte_addr_q <= pte_addr_d;
        low_q      <= low_d;
      end
      if (rvalid_d) begin
        raddr_q  <= raddr_d;
        xlated_q <= xlated_d;
      end
    end
  end

  assign xl_ready      = (state_q == ST_IDLE);
  assign xl_rsp_valid  = rvalid_q;
  assign xl_rsp_addr   = raddr_q;
  assign rsp_xlated    = xlated_q;
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = pte_addr_q;

endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
  import xlt_pkg::*;
#(
  parameter int unsigned   NUM_WIN   = 4,
  parameter logic [63:0]   DEV_BASE  = 64'h0000_0000_1000_0000,
  parameter int unsigned   OFF_SHIFT = 6,
  parameter int unsigned   OUT_BITS  = 34
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [63:0] reg_addr,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  output logic        reg_rsp_valid,
  output logic [63:0] reg_rdata,
  output logic        reg_err,
  input  logic        xl_valid,
  output logic        xl_ready,
  input  logic [63:0] xl_addr,
  output logic        xl_rsp_valid,
  output logic [63:0] xl_rsp_addr,
  output logic        mem_req_valid,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data
);

  logic [1:0]              rst_sync_q;
  logic                    rst_n_int;
  xlt_win_t [NUM_WIN-1:0]  win;
  logic                    hit;
  logic                    sel_sg;
  logic [DW-1:0]           sel_mask;
  logic [DW-1:0]           sel_tbase;
  logic                    rsp_xlated;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  xlt_regfile #(
    .NUM_WIN  (NUM_WIN),
    .DEV_BASE (DEV_BASE),
    .OFF_SHIFT(OFF_SHIFT)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .reg_req      (reg_req),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_size     (reg_size),
    .reg_wdata    (reg_wdata),
    .reg_rsp_valid(reg_rsp_valid),
    .reg_rdata    (reg_rdata),
    .reg_err      (reg_err),
    .win_o        (win)
  );

  xlt_match #(
    .NUM_WIN(NUM_WIN)
  ) u_match (
    .addr     (xl_addr),
    .win_i    (win),
    .hit      (hit),
    .sel_sg   (sel_sg),
    .sel_mask (sel_mask),
    .sel_tbase(sel_tbase)
  );

  xlt_engine #(
    .OUT_BITS(OUT_BITS)
  ) u_eng (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .xl_valid     (xl_valid),
    .xl_addr      (xl_addr),
    .xl_ready     (xl_ready),
    .xl_rsp_valid (xl_rsp_valid),
    .xl_rsp_addr  (xl_rsp_addr),
    .rsp_xlated   (rsp_xlated),
    .hit          (hit),
    .sel_sg       (sel_sg),
    .sel_mask     (sel_mask),
    .sel_tbase    (sel_tbase),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data)
  );

endmodule

// File: rtl/xlt_checker.sv
module xlt_checker #(
  parameter int unsigned OUT_BITS = 34
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_req,
  input logic        reg_rsp_valid,
  input logic        reg_err,
  input logic [63:0] reg_rdata,
  input logic        xl_valid,
  input logic        xl_ready,
  input logic        xl_rsp_valid,
  input logic [63:0] xl_rsp_addr,
  input logic        rsp_xlated,
  input logic        mem_req_valid
);

  // R2: every register request is answered in the next cycle
  p_reg_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> reg_rsp_valid);

  // R3: error responses carry no data
  p_err_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rsp_valid && reg_err) |-> (reg_rdata == 64'd0));

  // R9: one single-cycle read per lookup
  p_single_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R9: port busy while the read is out
  p_busy_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !xl_ready);

  // R11: translated results fit in OUT_BITS
  p_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_rsp_valid && rsp_xlated) |-> (xl_rsp_addr[63:OUT_BITS] == '0));

  // R12: an accepted request yields a response or a memory read next cycle
  p_accept_flow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_ready) |=> (xl_rsp_valid || mem_req_valid));

  // R12: a response never overlaps an issued read
  p_rsp_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    xl_rsp_valid |-> !mem_req_valid);

endmodule

bind pci_dma_xlate xlt_checker #(.OUT_BITS(OUT_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_req      (reg_req),
  .reg_rsp_valid(reg_rsp_valid),
  .reg_err      (reg_err),
  .reg_rdata    (reg_rdata),
  .xl_valid     (xl_valid),
  .xl_ready     (xl_ready),
  .xl_rsp_valid (xl_rsp_valid),
  .xl_rsp_addr  (xl_rsp_addr),
  .rsp_xlated   (rsp_xlated),
  .mem_req_valid(mem_req_valid)
);

// File: tb/pci_dma_xlate_tb.sv
`timescale 1ns/1ps
module pci_dma_xlate_tb;

  localparam logic [63:0] DEV_BASE = 64'h0000_0000_1000_0000;
  localparam logic [63:0] FIELD    = 64'h0000_0000_FFF0_0000;
  localparam logic [63:0] OMASK    = (64'd1 << 34) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [63:0] reg_addr = '0, reg_wdata = '0;
  logic [3:0]  reg_size = 4'd8;
  logic        reg_rsp_valid, reg_err;
  logic [63:0] reg_rdata;
  logic        xl_valid = 1'b0;
  logic        xl_ready;
  logic [63:0] xl_addr = '0;
  logic        xl_rsp_valid;
  logic [63:0] xl_rsp_addr;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [63:0] sb [4], sm [4], st [4];

  always #2.5 clk = ~clk;

  pci_dma_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rsp_valid(reg_rsp_valid), .reg_rdata(reg_rdata),
    .reg_err(reg_err),
    .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_addr(xl_addr),
    .xl_rsp_valid(xl_rsp_valid), .xl_rsp_addr(xl_rsp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] raddr(input int off);
    return DEV_BASE + (64'(off) << 6);
  endfunction

  // Model of the requirements
  function automatic int find_win(input logic [63:0] a);
    for (int i = 0; i < 4; i++) begin
      logic [63:0] cmp;
      cmp = ~sm[i] & FIELD;
      if ((((a ^ sb[i]) & cmp) == 64'd0) && sb[i][0]) return i;
    end
    return -1;
  endfunction

  function automatic logic [63:0] exp_direct(input int w, input logic [63:0] a);
    logic [63:0] p;
    p = (sm[w] & FIELD) | 64'hF_FFFF;
    return ((st[w] & ~p) | (a & p)) & OMASK;
  endfunction

  function automatic logic [63:0] exp_pte_addr(input int w, input logic [63:0] a);
    logic [63:0] f;
    f = sm[w] & FIELD;
    return (st[w] & ~((f >> 10) | 64'h3FF)) | ((a & (f | (64'h7F << 13))) >> 10);
  endfunction

  function automatic logic [63:0] pte_of(input logic [63:0] x);
    return x ^ {x[31:0], x[63:32]} ^ 64'h5A5A_0F0F_3C3C_9697;
  endfunction

  function automatic logic [63:0] exp_sg(input logic [63:0] e, input logic [63:0] a);
    return (((e & ~64'd1) << 12) | (a & 64'h1FFF)) & OMASK;
  endfunction

  task automatic reg_acc(input bit we, input logic [63:0] addr, input logic [3:0] size,
                         input logic [63:0] wd, output logic [63:0] rd, output logic err);
    @(negedge clk);
    reg_req = 1'b1; reg_we = we; reg_addr = addr; reg_size = size; reg_wdata = wd;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
    chk("R2", "reg_rsp_valid", 64'(reg_rsp_valid), 64'd1);
    rd = reg_rdata; err = reg_err;
  endtask

  task automatic wr(input int off, input logic [63:0] d, input string req);
    logic [63:0] rd; logic err;
    reg_acc(1'b1, raddr(off), 4'd8, d, rd, err);
    chk(req, "write err", 64'(err), 64'd0);
    if (off < 4)       sb[off] = d;
    else if (off < 8)  sm[off-4] = d;
    else if (off < 12) st[off-8] = d;
  endtask

  task automatic rdchk(input int off, input logic [63:0] exp, input string req);
    logic [63:0] rd; logic err;
    reg_acc(1'b0, raddr(off), 4'd8, 64'd0, rd, err);
    chk(req, $sformatf("read off %0d", off), rd, exp);
    chk(req, "read err", 64'(err), 64'd0);
  endtask

  task automatic bad(input bit we, input logic [63:0] addr, input logic [3:0] size,
                     input string req);
    logic [63:0] rd; logic err;
    reg_acc(we, addr, size, 64'hDEAD_BEEF_0BAD_F00D, rd, err);
    chk(req, "error flag", 64'(err), 64'd1);
    chk(req, "error rdata", rd, 64'd0);
  endtask

  task automatic do_xl(input logic [63:0] a, input string req);
    int w;
    w = find_win(a);
    @(negedge clk);
    chk("R12", "ready idle", 64'(xl_ready), 64'd1);
    xl_valid = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_valid = 1'b0;
    if (w >= 0 && sb[w][1]) begin
      logic [63:0] pa, e;
      int d;
      pa = exp_pte_addr(w, a);
      chk("R9", "mem_req_valid", 64'(mem_req_valid), 64'd1);
      chk("R9", "mem_req_addr", mem_req_addr, pa);
      chk("R9", "ready low", 64'(xl_ready), 64'd0);
      @(negedge clk);
      chk("R9", "single read", 64'(mem_req_valid), 64'd0);
      d = int'($urandom % 3);
      repeat (d) @(negedge clk);
      chk("R9", "still busy", 64'(xl_ready), 64'd0);
      e = pte_of(pa);
      mem_rsp_valid = 1'b1; mem_rsp_data = e;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R12", "sg rsp_valid", 64'(xl_rsp_valid), 64'd1);
      chk(req, "sg result R10", xl_rsp_addr, exp_sg(e, a));
    end else begin
      chk("R12", "rsp_valid", 64'(xl_rsp_valid), 64'd1);
      chk("R12", "no read", 64'(mem_req_valid), 64'd0);
      chk(req, w >= 0 ? "direct R8" : "pass R11", xl_rsp_addr,
          (w >= 0) ? exp_direct(w, a) : a);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed_r;
    seed_r = $urandom(32'h00C0_FFEE);
    for (int i = 0; i < 4; i++) begin sb[i] = '0; sm[i] = '0; st[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    chk("R12", "ready after reset", 64'(xl_ready), 64'd1);
    for (int i = 0; i < 12; i++) rdchk(i, 64'd0, "R1");
    rdchk(12, 64'h0000_0021_0010_0000, "R1");

    // R4: status registers
    rdchk(13, 64'd0, "R4");
    rdchk(14, 64'd0, "R4");
    rdchk(15, 64'd0, "R4");
    wr(13, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    rdchk(13, 64'd0, "R4");
    wr(15, 64'h1234_5678_9ABC_DEF0, "R4");
    rdchk(15, 64'd0, "R4");
    bad(1'b1, raddr(14), 4'd8, "R4");

    // R2: control and window write / read back
    wr(12, 64'hA5A5_0000_FFFF_1234, "R2");
    rdchk(12, 64'hA5A5_0000_FFFF_1234, "R2");
    wr(0, 64'h0000_0000_4000_0000, "R2");
    rdchk(0, 64'h0000_0000_4000_0000, "R2");

    // R3: illegal accesses leave registers alone
    bad(1'b1, raddr(0), 4'd4, "R3");
    rdchk(0, 64'h0000_0000_4000_0000, "R3");
    bad(1'b0, raddr(0), 4'd2, "R3");
    bad(1'b1, raddr(16), 4'd8, "R3");
    bad(1'b0, raddr(16), 4'd8, "R3");
    bad(1'b1, DEV_BASE - 64'd64, 4'd8, "R3");
    rdchk(12, 64'hA5A5_0000_FFFF_1234, "R3");

    // R11: no windows enabled -> pass-through
    do_xl(64'hFFFF_0000_4000_5678, "R11");

    // R6: window 0 hits but disabled; window 1 enabled
    wr(1, 64'h0000_0000_4000_0001, "R6");
    wr(9, 64'hF000_0003_8760_0000, "R6");
    do_xl(64'h0000_0000_4001_2345, "R6");
    chk("R6", "skip disabled", xl_rsp_addr, 64'h0000_0003_8761_2345);

    // R7: window 0 enabled too, lower index wins
    wr(0, 64'h0000_0000_4000_0001, "R7");
    wr(8, 64'h0000_0002_0000_0000, "R7");
    do_xl(64'h0000_0000_4001_2345, "R7");
    chk("R7", "priority", xl_rsp_addr, 64'h0000_0002_0001_2345);

    // R5: differing compared bit misses; masked bit ignored
    do_xl(64'h0000_0000_4201_2345, "R5");
    chk("R5", "miss passes", xl_rsp_addr, 64'h0000_0000_4201_2345);
    wr(4, 64'h0000_0000_0200_0000, "R5");
    do_xl(64'h0000_0000_4201_2345, "R5");

    // R9/R10: scatter-gather window
    wr(0, 64'd0, "R9");
    wr(1, 64'd0, "R9");
    wr(2, 64'h0000_0000_8000_0003, "R9");
    wr(6, 64'h0000_0000_0030_0000, "R9");
    wr(10, 64'h0000_0001_2345_6000, "R9");
    do_xl(64'h0000_0000_8035_4ABC, "R10");
    do_xl(64'h1234_0000_8000_1FFF, "R10");

    // Random mix
    for (int r = 0; r < 40; r++) begin
      for (int w = 0; w < 4; w++) begin
        logic [63:0] b, m;
        b = {$urandom, $urandom};
        b[0] = ($urandom % 4) != 0;
        b[1] = $urandom % 2;
        m = {$urandom, $urandom};
        if ($urandom % 3 == 0) m = m & ~FIELD;
        wr(w, b, "R2");
        wr(4 + w, m, "R2");
        wr(8 + w, {$urandom, $urandom}, "R2");
      end
      for (int k = 0; k < 8; k++) begin
        logic [63:0] a, cmp;
        int j;
        j = int'($urandom % 4);
        a = {$urandom, $urandom};
        cmp = ~sm[j] & FIELD;
        if ($urandom % 4 != 0) a = (a & ~cmp) | (sb[j] & cmp);
        do_xl(a, "R8");
      end
    end

    finish_run();
  end

endmodule